// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This block carries out single-cycle accesses to the on-chip data store of a small 8-bit controller. That store has two parts: a 256-byte scratch RAM and a 128-entry special-register file that answers to byte addresses 0x80 to 0xFF. One address datapath serves three ways of looking at this storage. The first is a plain byte view. The second is a view of eight working registers, relocated by a bank number held in the status register. The third is a single-bit view, which folds the bit-addressable RAM window and the bit-addressable special registers into one 256-entry bit space.

Every clock edge is one access. The caller presents a mode, an address, write data and a write strobe. On the edge the unit writes the target, and it registers the old contents of the addressed byte or bit onto the read port. A bit write reads the byte, replaces one bit and stores the byte back, all inside that one cycle. The status register is kept in a dedicated register rather than in the special-register array. Its current value is always visible on an output. Its bank field steers register-mode accesses from the cycle after it is written.

Top module: `idata_access_unit`

## Requirements
- R1: After synchronous reset, `rdata` and `psw_q` are 0x00, so register bank 0 is selected.
- R2: Mode 0 (byte) with address 0x00–0x7F reads and writes scratch RAM at that address. `rdata` after the edge holds the byte as it was before that access's write.
- R3: Mode 0 with address 0x80–0xFF reads and writes the special-register file at offset address−0x80, without touching scratch RAM.
- R4: Mode 1 (register) uses address bits [2:0] as register number n and ignores bits [7:3]. It reaches scratch RAM byte 8·k + n, where k is `psw_q[4:3]`.
- R5: Mode 2 (bit) with bit address b < 0x80 selects RAM byte 0x20 + (b >> 3), bit b & 7. `rdata` returns that old bit in bit 0, with bits [7:1] zero.
- R6: Mode 2 with b ≥ 0x80 selects the special register at byte address b & 0xF8, bit b & 7.
- R7: A bit write stores `wdata[0]` into the selected bit and leaves the other seven bits of the byte unchanged.
- R8: The status register lives at byte address 0xD0, and its bits can be written through bit addresses 0xD0–0xD7. A byte or bit write to it updates `psw_q` at that edge, and the new bank applies to the next access.
- R9: Mode 3 is idle: nothing is written even with `wr_en` high, and `rdata` becomes 0x00.
- R10: With `wr_en` low, no access in any mode changes any storage or `psw_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 byte, 1 working register, 2 bit, 3 idle |
| addr | input | 8 | Byte address, register number or bit address |
| wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| wr_en | input | 1 | Write strobe for this cycle's access |
| rdata | output | 8 | Registered old contents of the accessed byte or bit |
| psw_q | output | 8 | Registered status register |

## Verification
The hardest case is a bank switch made through the bit view. Bit address 0xD3 aliases bank-select bit 0 of the status register, so a bit write there has to redirect a register-mode access issued on the very next edge. The bench sets up this case directly. It writes R2 in bank 0, flips bit 0xD3, and then writes R2 again on the immediately following cycle. Byte reads of RAM 0x02 and 0x0A then show whether each write landed in the right bank.

// File: rtl/idau_pkg.sv
package idau_pkg;
  localparam int BYTE_W = 8;
  localparam int BPOS_W = 3;

  typedef enum logic [1:0] {
    AM_BYTE = 2'd0,
    AM_REG  = 2'd1,
    AM_BIT  = 2'd2,
    AM_IDLE = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    TG_NONE = 2'd0,
    TG_RAM  = 2'd1,
    TG_SFR  = 2'd2
  } target_e;
endpackage

// File: rtl/idau_decode.sv
module idau_decode
  import idau_pkg::*;
#(
  parameter logic [7:0] BITRAM_BASE = 8'h20,
  parameter int         BANK_W      = 2
) (
  input  acc_mode_e               mode,
  input  logic [BYTE_W-1:0]       addr,
  input  logic [BANK_W-1:0]       bank,
  output target_e                 tgt,
  output logic [BYTE_W-1:0]       idx,
  output logic [BPOS_W-1:0]       bit_pos,
  output logic                    is_bit
);
  localparam int REGN_W = 3;

  always_comb begin
    tgt     = TG_NONE;
    idx     = '0;
    bit_pos = '0;
    is_bit  = 1'b0;
    unique case (mode)
      AM_BYTE: begin
        if (addr[7]) begin
          tgt = TG_SFR;
          idx = {1'b0, addr[6:0]};
        end else begin
          tgt = TG_RAM;
          idx = addr;
        end
      end
      AM_REG: begin
        tgt = TG_RAM;
        idx = {{(BYTE_W-BANK_W-REGN_W){1'b0}}, bank, addr[REGN_W-1:0]};
      end
      AM_BIT: begin
        is_bit  = 1'b1;
        bit_pos = addr[BPOS_W-1:0];
        if (addr[7]) begin
          tgt = TG_SFR;
          idx = {1'b0, addr[6:3], 3'b000};
        end else begin
          tgt = TG_RAM;
          idx = BITRAM_BASE + {4'b0000, addr[6:3]};
        end
      end
      default: tgt = TG_NONE;
    endcase
  end
endmodule

// File: rtl/idau_store.sv
module idau_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/idau_merge.sv
module idau_merge
  import idau_pkg::*;
(
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              is_bit,
  input  logic [BPOS_W-1:0] bit_pos,
  input  logic              active,
  output logic [BYTE_W-1:0] new_byte,
  output logic [BYTE_W-1:0] rd_val
);
  logic [BYTE_W-1:0] sel_mask;

  generate
    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
      assign sel_mask[i] = (bit_pos == BPOS_W'(i));
    end
  endgenerate

  always_comb begin
    if (is_bit)
      new_byte = (old_byte & ~sel_mask) | ({BYTE_W{wdata[0]}} & sel_mask);
    else
      new_byte = wdata;
  end

  always_comb begin
    if (!active)
      rd_val = '0;
    else if (is_bit)
      rd_val = {{(BYTE_W-1){1'b0}}, |(old_byte & sel_mask)};
    else
      rd_val = old_byte;
  end
endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
  import idau_pkg::*;
#(
  parameter int         RAM_DEPTH   = 256,
  parameter int         SFR_DEPTH   = 128,
  parameter logic [6:0] PSW_OFFSET  = 7'h50,
  parameter int         BANK_LSB    = 3,
  parameter logic [7:0] BITRAM_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  output logic [7:0] rdata,
  output logic [7:0] psw_q
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int SFR_AW = $clog2(SFR_DEPTH);
  localparam int BANK_W = 2;

  target_e           tgt;
  logic [BYTE_W-1:0] idx;
  logic [BPOS_W-1:0] bit_pos;
  logic              is_bit;
  logic [BYTE_W-1:0] ram_rd, sfr_rd, old_byte, new_byte, rd_val;
  logic              hit_psw, ram_we, sfr_we, active;

  idau_decode #(.BITRAM_BASE(BITRAM_BASE), .BANK_W(BANK_W)) u_dec (
    .mode   (acc_mode_e'(mode)),
    .addr   (addr),
    .bank   (psw_q[BANK_LSB +: BANK_W]),
    .tgt    (tgt),
    .idx    (idx),
    .bit_pos(bit_pos),
    .is_bit (is_bit)
  );

  assign active  = (tgt != TG_NONE);
  assign hit_psw = (tgt == TG_SFR) && (idx[SFR_AW-1:0] == PSW_OFFSET);
  assign ram_we  = wr_en && (tgt == TG_RAM);
  assign sfr_we  = wr_en && (tgt == TG_SFR) && !hit_psw;

  idau_store #(.DEPTH(RAM_DEPTH), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(idx[RAM_AW-1:0]),
    .wdata(new_byte), .rdata(ram_rd)
  );

  idau_store #(.DEPTH(SFR_DEPTH), .DW(BYTE_W)) u_sfr (
    .clk(clk), .we(sfr_we), .addr(idx[SFR_AW-1:0]),
    .wdata(new_byte), .rdata(sfr_rd)
  );

  always_comb begin
    unique case (tgt)
      TG_RAM:  old_byte = ram_rd;
      TG_SFR:  old_byte = hit_psw ? psw_q : sfr_rd;
      default: old_byte = '0;
    endcase
  end

  idau_merge u_merge (
    .old_byte(old_byte), .wdata(wdata), .is_bit(is_bit),
    .bit_pos(bit_pos), .active(active),
    .new_byte(new_byte), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q <= '0;
      rdata <= '0;
    end else begin
      rdata <= rd_val;
      if (wr_en && hit_psw) psw_q <= new_byte;
    end
  end

  // Assertions
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (psw_q == 8'h00 && rdata == 8'h00));

  assert_bank_route_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> (tgt == TG_RAM && idx[7:5] == 3'b000 &&
                        idx[4:3] == psw_q[BANK_LSB +: BANK_W]));

  assert_bitram_window_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !addr[7]) |-> (tgt == TG_RAM && idx >= BITRAM_BASE &&
                                    idx <= BITRAM_BASE + 8'h0F));

  assert_bitsfr_align_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && addr[7]) |-> (tgt == TG_SFR && idx[2:0] == 3'b000));

  assert_single_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (is_bit && wr_en) |-> ($countones(new_byte ^ old_byte) <= 1));

  assert_psw_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_psw) |=> $stable(psw_q));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |=> (rdata == 8'h00));

  assert_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (!ram_we && !sfr_we));
endmodule

// File: tb/idata_access_unit_test.sv
`timescale 1ns/1ps
module idata_access_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd3;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic [7:0] rdata, psw_q;

  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idata_access_unit uut (
    .clk(clk), .rst(rst), .mode(mode), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .psw_q(psw_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
    end
  endtask

  // One access: drive after a falling edge, sample after the next rising edge.
  task automatic acc(input logic [1:0] m, input logic [7:0] a,
                     input logic [7:0] d, input logic w,
                     output logic [7:0] r);
    mode = m; addr = a; wdata = d; wr_en = w;
    @(negedge clk);
    r = rdata;
    mode = 2'd3; wr_en = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    acc(2'd0, a, d, 1'b1, r);
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] r);
    acc(2'd0, a, 8'h00, 1'b0, r);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rdata after reset", rdata, 8'h00);
    chk("R1", "psw after reset", psw_q, 8'h00);
    acc(2'd1, 8'h07, 8'h99, 1'b1, r);
    rd_byte(8'h07, r);
    chk("R1", "bank0 R7 lands at 0x07", r, 8'h99);
  endtask

  task automatic t_byte_ram;
    logic [7:0] r;
    wr_byte(8'h3C, 8'hA5);
    rd_byte(8'h3C, r);
    chk("R2", "ram 0x3C", r, 8'hA5);
    acc(2'd0, 8'h3C, 8'h11, 1'b1, r);
    chk("R2", "write returns old byte", r, 8'hA5);
    rd_byte(8'h3C, r);
    chk("R2", "ram 0x3C rewritten", r, 8'h11);
    wr_byte(8'h7F, 8'h5A);
    rd_byte(8'h7F, r);
    chk("R2", "ram 0x7F", r, 8'h5A);
  endtask

  task automatic t_byte_sfr;
    logic [7:0] r;
    wr_byte(8'h10, 8'h00);
    wr_byte(8'h90, 8'h77);
    rd_byte(8'h90, r);
    chk("R3", "sfr 0x90", r, 8'h77);
    rd_byte(8'h10, r);
    chk("R3", "ram 0x10 not aliased", r, 8'h00);
    wr_byte(8'hFF, 8'hE1);
    rd_byte(8'hFF, r);
    chk("R3", "sfr 0xFF", r, 8'hE1);
  endtask

  task automatic t_regbank;
    logic [7:0] r;
    for (int b = 0; b < 4; b++) begin
      wr_byte(8'hD0, 8'(b << 3));
      chk("R8", "psw after byte write", psw_q, 8'(b << 3));
      acc(2'd1, 8'hAD, 8'(8'h40 + b), 1'b1, r);
      rd_byte(8'(b * 8 + 5), r);
      chk("R4", "register 5 in bank", r, 8'(8'h40 + b));
    end
    wr_byte(8'hD0, 8'h00);
  endtask

  task automatic t_bit_ram;
    logic [7:0] r;
    wr_byte(8'h25, 8'h00);
    acc(2'd2, 8'h2B, 8'h01, 1'b1, r);
    rd_byte(8'h25, r);
    chk("R5", "bit 0x2B sets byte 0x25 bit3", r, 8'h08);
    acc(2'd2, 8'h2B, 8'h00, 1'b0, r);
    chk("R5", "bit read 0x2B", r, 8'h01);
    acc(2'd2, 8'h2A, 8'h00, 1'b0, r);
    chk("R5", "bit read 0x2A", r, 8'h00);
    acc(2'd2, 8'h2F, 8'h01, 1'b1, r);
    acc(2'd2, 8'h2B, 8'h00, 1'b1, r);
    rd_byte(8'h25, r);
    chk("R7", "only selected bits change", r, 8'h80);
    wr_byte(8'h2F, 8'hFF);
    acc(2'd2, 8'h7F, 8'h00, 1'b1, r);
    rd_byte(8'h2F, r);
    chk("R7", "clear top bit 0x7F", r, 8'h7F);
    wr_byte(8'h20, 8'h00);
    acc(2'd2, 8'h00, 8'hFE, 1'b1, r);
    rd_byte(8'h20, r);
    chk("R7", "bit 0x00 uses wdata[0] only", r, 8'h00);
  endtask

  task automatic t_bit_sfr;
    logic [7:0] r;
    wr_byte(8'hA0, 8'h00);
    acc(2'd2, 8'hA6, 8'h01, 1'b1, r);
    rd_byte(8'hA0, r);
    chk("R6", "bit 0xA6 sets sfr 0xA0 bit6", r, 8'h40);
    acc(2'd2, 8'hA6, 8'h00, 1'b0, r);
    chk("R6", "bit read 0xA6", r, 8'h01);
    wr_byte(8'hF8, 8'h0F);
    acc(2'd2, 8'hFF, 8'h01, 1'b1, r);
    rd_byte(8'hF8, r);
    chk("R6", "bit 0xFF sets sfr 0xF8 bit7", r, 8'h8F);
  endtask

  task automatic t_psw_bit;
    logic [7:0] r;
    wr_byte(8'hD0, 8'h00);
    acc(2'd1, 8'h02, 8'h11, 1'b1, r);
    mode = 2'd2; addr = 8'hD3; wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk);
    chk("R8", "psw after bit 0xD3", psw_q, 8'h08);
    mode = 2'd1; addr = 8'h02; wdata = 8'h22; wr_en = 1'b1;
    @(negedge clk);
    mode = 2'd3; wr_en = 1'b0;
    rd_byte(8'h02, r);
    chk("R8", "bank0 R2 kept", r, 8'h11);
    rd_byte(8'h0A, r);
    chk("R8", "bank1 R2 written next cycle", r, 8'h22);
    rd_byte(8'hD0, r);
    chk("R8", "psw read as byte", r, 8'h08);
    acc(2'd2, 8'hD4, 8'h00, 1'b0, r);
    chk("R8", "bit 0xD4 reads 0", r, 8'h00);
    wr_byte(8'hD0, 8'h00);
  endtask

  task automatic t_idle;
    logic [7:0] r;
    wr_byte(8'h3C, 8'h11);
    acc(2'd3, 8'h3C, 8'hFF, 1'b1, r);
    chk("R9", "idle rdata", r, 8'h00);
    rd_byte(8'h3C, r);
    chk("R9", "idle leaves ram", r, 8'h11);
    chk("R9", "idle leaves psw", psw_q, 8'h00);
  endtask

  task automatic t_nowrite;
    logic [7:0] r;
    wr_byte(8'h50, 8'h33);
    acc(2'd0, 8'h50, 8'hCC, 1'b0, r);
    chk("R10", "read without strobe", r, 8'h33);
    rd_byte(8'h50, r);
    chk("R10", "byte unchanged", r, 8'h33);
    wr_byte(8'h25, 8'h00);
    acc(2'd2, 8'h2B, 8'h01, 1'b0, r);
    rd_byte(8'h25, r);
    chk("R10", "bit access without strobe", r, 8'h00);
    acc(2'd2, 8'hD3, 8'h01, 1'b0, r);
    chk("R10", "psw unchanged", psw_q, 8'h00);
  endtask

  initial begin
    t_reset();
    t_byte_ram();
    t_byte_sfr();
    t_regbank();
    t_bit_ram();
    t_bit_sfr();
    t_psw_bit();
    t_idle();
    t_nowrite();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule